// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Logic

This block sits beside the register file of a 16550-style serial port. Each cycle it looks at five interrupt sources, masks each with its enable bit, and reports the most urgent one through an identification byte and a single interrupt request line. The host learns which source needs service by reading the identification value. The sources are receiver line errors, character timeout, received data, transmit holding empty and modem status change.

The block also tracks transmitter state. It holds the THRE and TEMT line status bits. It also holds a hidden transmit-empty pending flag, which is not visible in any register. Empty events from the transmitter set that flag. A host write to the transmit holding register clears it. A read of the identification value also clears it, but only when transmit-holding-empty is the source being reported. The FIFOs, the register decode and the modem input sampling are outside this block.

Top module: `uart_irq_id`

## Requirements
- R1: Receiver line status is the highest priority source. When the line status enable (`ier_i[2]`) is set and overrun or break is flagged, `iir_o[3:0]` is 4'b0110.
- R2: Character timeout is the next source down. When the receive enable (`ier_i[0]`) is set and `timeout_pend_i` is high, with no line status source active, `iir_o[3:0]` is 4'b1100. With `ier_i[0]` clear, the timeout has no effect.
- R3: Received data is the third source. When `ier_i[0]` is set and data-ready is set, and either the FIFO is disabled or `rx_count_i` >= `rx_trig_i`, with no higher source active, `iir_o[3:0]` is 4'b0100.
- R4: Transmit holding empty ranks below received data and above modem status. When `ier_i[1]` is set and the hidden pending flag is set, `iir_o[3:0]` is 4'b0010.
- R5: Modem status is the lowest priority source. When `ier_i[3]` is set and any bit of `msr_delta_i` is set, `iir_o[3:0]` is 4'b0000.
- R6: When no source is active, `iir_o[3:0]` is 4'b0001 and `irq_o` is low. Otherwise `irq_o` is high. `iir_o[7:6]` is 2'b11 when the FIFO is enabled and 2'b00 when it is not. `iir_o[5:4]` is always 2'b00.
- R7: An identification read (`iir_rd_i`) clears the pending flag in the next cycle only if `iir_o[3:0]` is 4'b0010 during that read. A read that reports any other value leaves the flag set.
- R8: A transmit holding write (`thr_wr_i`) clears the pending flag and `thre_o` in the next cycle. With the FIFO enabled, it also clears `temt_o`; with the FIFO disabled, `temt_o` is unchanged. If a write and a holding-empty event arrive in the same cycle, the write wins.
- R9: After reset, `thre_o` and `temt_o` are 1 and the pending flag is clear, so enabling only the transmit-empty source gives `iir_o[3:0]` = 4'b0001.
- R10: A holding-empty event (`hold_empty_i`) sets `thre_o` and the pending flag in the next cycle. A shift-empty event (`shift_empty_i`) sets `temt_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_i | input | 4 | Enables: [0] receive, [1] transmit empty, [2] line status, [3] modem |
| lsr_oe_i | input | 1 | Overrun flagged |
| lsr_bi_i | input | 1 | Break flagged |
| lsr_dr_i | input | 1 | Data ready |
| fifo_en_i | input | 1 | FIFO mode enabled |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| rx_trig_i | input | CNT_W | Receive trigger level |
| timeout_pend_i | input | 1 | Character timeout pending |
| msr_delta_i | input | DELTA_W | Modem status change bits |
| thr_wr_i | input | 1 | Host write strobe for the transmit holding register |
| iir_rd_i | input | 1 | Host read strobe for the identification register |
| hold_empty_i | input | 1 | Transmit holding register or FIFO became empty |
| shift_empty_i | input | 1 | Transmit shifter became empty |
| iir_o | output | 8 | Identification value |
| irq_o | output | 1 | Interrupt request |
| thre_o | output | 1 | Holding-empty status bit |
| temt_o | output | 1 | Transmitter-empty status bit |

## Verification
The bench checks the exact ordering between neighbouring sources. If the order were wrong, the transmit-empty ID would hide pending receive data, or the modem ID would hide a transmit-empty condition. It checks a read taken while a higher source is being reported. A design that cleared the flag on every read would then lose the transmit interrupt when the receive data goes away. It checks the FIFO count exactly at the trigger level and one below it, to catch an off-by-one in the comparison. It checks that TEMT is kept on a non-FIFO write, and that a write issued in the same cycle as an empty event wins.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  // Bit positions inside the enable vector
  localparam int IE_RX    = 0;
  localparam int IE_THRE  = 1;
  localparam int IE_LINE  = 2;
  localparam int IE_MODEM = 3;
  localparam int IE_W     = 4;

  // Source index, highest priority first
  localparam int SRC_LINE    = 0;
  localparam int SRC_TIMEOUT = 1;
  localparam int SRC_RXDATA  = 2;
  localparam int SRC_THRE    = 3;
  localparam int SRC_MODEM   = 4;
  localparam int NUM_SRC     = 5;

  typedef enum logic [2:0] {
    ID_MODEM   = 3'b000,
    ID_THRE    = 3'b001,
    ID_RXDATA  = 3'b010,
    ID_LINE    = 3'b011,
    ID_TIMEOUT = 3'b110
  } irq_id_e;

  function automatic irq_id_e id_of_src(input int idx);
    case (idx)
      SRC_LINE:    return ID_LINE;
      SRC_TIMEOUT: return ID_TIMEOUT;
      SRC_RXDATA:  return ID_RXDATA;
      SRC_THRE:    return ID_THRE;
      default:     return ID_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/rx_level_cmp.sv
module rx_level_cmp #(
  parameter int CNT_W = 5
) (
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] trig_i,
  output logic             level_ok_o
);
  // Without the FIFO, a single character is enough
  always_comb begin
    if (!fifo_en_i) level_ok_o = 1'b1;
    else            level_ok_o = (count_i >= trig_i);
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,
  output irq_id_e            id_o,
  output logic               active_o
);
  always_comb begin
    id_o     = ID_MODEM;
    active_o = 1'b0;
    // Walk from the lowest priority up so the highest active source wins
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        id_o     = id_of_src(k);
        active_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tx_pend_track.sv
module tx_pend_track (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_wr_i,
  input  logic hold_empty_i,
  input  logic shift_empty_i,
  input  logic fifo_en_i,
  input  logic iir_rd_i,
  input  logic thre_shown_i,
  output logic pend_o,
  output logic thre_o,
  output logic temt_o
);
  logic pend_q, pend_d;
  logic thre_q, thre_d;
  logic temt_q, temt_d;
  logic upd_en;

  assign upd_en = thr_wr_i | hold_empty_i | shift_empty_i | iir_rd_i;

  always_comb begin
    pend_d = pend_q;
    thre_d = thre_q;
    temt_d = temt_q;
    if (iir_rd_i && thre_shown_i) pend_d = 1'b0;
    if (hold_empty_i) begin
      pend_d = 1'b1;
      thre_d = 1'b1;
    end
    if (shift_empty_i) temt_d = 1'b1;
    // A new character written this cycle overrides any empty event
    if (thr_wr_i) begin
      pend_d = 1'b0;
      thre_d = 1'b0;
      if (fifo_en_i) temt_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      thre_q <= 1'b1;
      temt_q <= 1'b1;
    end else if (upd_en) begin
      pend_q <= pend_d;
      thre_q <= thre_d;
      temt_q <= temt_d;
    end
  end

  assign pend_o = pend_q;
  assign thre_o = thre_q;
  assign temt_o = temt_q;
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DELTA_W    = 4,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IE_W-1:0]    ier_i,
  input  logic               lsr_oe_i,
  input  logic               lsr_bi_i,
  input  logic               lsr_dr_i,
  input  logic               fifo_en_i,
  input  logic [CNT_W-1:0]   rx_count_i,
  input  logic [CNT_W-1:0]   rx_trig_i,
  input  logic               timeout_pend_i,
  input  logic [DELTA_W-1:0] msr_delta_i,
  input  logic               thr_wr_i,
  input  logic               iir_rd_i,
  input  logic               hold_empty_i,
  input  logic               shift_empty_i,
  output logic [7:0]         iir_o,
  output logic               irq_o,
  output logic               thre_o,
  output logic               temt_o
);
  logic               level_ok;
  logic               tx_pend;
  logic [NUM_SRC-1:0] req;
  irq_id_e            cur_id;
  logic               any_active;
  logic               thre_shown;

  rx_level_cmp #(.CNT_W(CNT_W)) u_level (
    .fifo_en_i  (fifo_en_i),
    .count_i    (rx_count_i),
    .trig_i     (rx_trig_i),
    .level_ok_o (level_ok)
  );

  always_comb begin
    req              = '0;
    req[SRC_LINE]    = ier_i[IE_LINE]  & (lsr_oe_i | lsr_bi_i);
    req[SRC_TIMEOUT] = ier_i[IE_RX]    & timeout_pend_i;
    req[SRC_RXDATA]  = ier_i[IE_RX]    & lsr_dr_i & level_ok;
    req[SRC_THRE]    = ier_i[IE_THRE]  & tx_pend;
    req[SRC_MODEM]   = ier_i[IE_MODEM] & (|msr_delta_i);
  end

  irq_prio_enc u_enc (
    .req_i    (req),
    .id_o     (cur_id),
    .active_o (any_active)
  );

  assign thre_shown = any_active && (cur_id == ID_THRE);

  tx_pend_track u_tx (
    .clk           (clk),
    .rst_n         (rst_n),
    .thr_wr_i      (thr_wr_i),
    .hold_empty_i  (hold_empty_i),
    .shift_empty_i (shift_empty_i),
    .fifo_en_i     (fifo_en_i),
    .iir_rd_i      (iir_rd_i),
    .thre_shown_i  (thre_shown),
    .pend_o        (tx_pend),
    .thre_o        (thre_o),
    .temt_o        (temt_o)
  );

  assign iir_o = {{2{fifo_en_i}}, 2'b00, cur_id, ~any_active};
  assign irq_o = any_active;
endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ier_i,
  input logic       lsr_oe_i,
  input logic       lsr_bi_i,
  input logic       fifo_en_i,
  input logic       thr_wr_i,
  input logic       iir_rd_i,
  input logic       hold_empty_i,
  input logic [7:0] iir_o,
  input logic       thre_o,
  input logic       temt_o
);
  p_line_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_i[2] && (lsr_oe_i || lsr_bi_i)) |-> (iir_o[3:0] == 4'b0110));

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd_i && iir_o[3:0] == 4'b0010 && !hold_empty_i) |=> (iir_o[3:0] != 4'b0010));

  p_write_thre_r8: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr_i |=> !thre_o);

  p_write_temt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr_i && fifo_en_i) |=> !temt_o);

  p_keep_temt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr_i && !fifo_en_i && temt_o) |=> temt_o);

  p_empty_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_empty_i && !thr_wr_i) |=> thre_o);
endmodule

bind uart_irq_id uart_irq_id_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ier_i        (ier_i),
  .lsr_oe_i     (lsr_oe_i),
  .lsr_bi_i     (lsr_bi_i),
  .fifo_en_i    (fifo_en_i),
  .thr_wr_i     (thr_wr_i),
  .iir_rd_i     (iir_rd_i),
  .hold_empty_i (hold_empty_i),
  .iir_o        (iir_o),
  .thre_o       (thre_o),
  .temt_o       (temt_o)
);

// File: tb/tb_uart_irq_id.sv
module tb_uart_irq_id;
  localparam int CNT_W = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] ier;
  logic       oe, bi, dr, fe, to;
  logic [4:0] cnt, trig;
  logic [3:0] delta;
  logic       thr_wr, iir_rd, hold_empty, shift_empty;
  logic [7:0] iir;
  logic       irq, thre, temt;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  uart_irq_id dut (
    .clk(clk), .rst_n(rst_n), .ier_i(ier), .lsr_oe_i(oe), .lsr_bi_i(bi),
    .lsr_dr_i(dr), .fifo_en_i(fe), .rx_count_i(cnt), .rx_trig_i(trig),
    .timeout_pend_i(to), .msr_delta_i(delta), .thr_wr_i(thr_wr),
    .iir_rd_i(iir_rd), .hold_empty_i(hold_empty), .shift_empty_i(shift_empty),
    .iir_o(iir), .irq_o(irq), .thre_o(thre), .temt_o(temt)
  );

  // {ier, oe, bi, dr, fe, cnt, trig, to, delta, expected iir}
  localparam int NV = 12;
  localparam logic [30:0] VEC [NV] = '{
    {4'b0000, 1'b1, 1'b1, 1'b1, 1'b1, 5'd5,  5'd1,  1'b1, 4'hF, 8'hC1},  // R6
    {4'b1111, 1'b1, 1'b1, 1'b1, 1'b1, 5'd5,  5'd1,  1'b1, 4'hF, 8'hC6},  // R1
    {4'b1111, 1'b0, 1'b1, 1'b1, 1'b1, 5'd5,  5'd1,  1'b1, 4'hF, 8'hC6},  // R1
    {4'b1011, 1'b1, 1'b0, 1'b1, 1'b1, 5'd8,  5'd8,  1'b1, 4'h0, 8'hCC},  // R2
    {4'b1111, 1'b0, 1'b0, 1'b1, 1'b1, 5'd8,  5'd8,  1'b0, 4'hF, 8'hC4},  // R3
    {4'b1111, 1'b0, 1'b0, 1'b1, 1'b1, 5'd7,  5'd8,  1'b0, 4'hF, 8'hC0},  // R5
    {4'b1111, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  5'd8,  1'b0, 4'h0, 8'h04},  // R3
    {4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  5'd8,  1'b0, 4'h0, 8'h01},  // R6
    {4'b1000, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  5'd0,  1'b0, 4'h4, 8'h00},  // R5
    {4'b0111, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0,  5'd0,  1'b0, 4'hF, 8'hC1},  // R5
    {4'b1110, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  5'd0,  1'b1, 4'h0, 8'h01},  // R2
    {4'b1111, 1'b0, 1'b0, 1'b1, 1'b1, 5'd16, 5'd16, 1'b0, 4'h0, 8'hC4}   // R3
  };

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_quiet();
    ier = 4'b0000; oe = 0; bi = 0; dr = 0; fe = 0; to = 0;
    cnt = '0; trig = '0; delta = '0;
  endtask

  task automatic pulse(input logic w, input logic r, input logic he, input logic se);
    @(negedge clk);
    thr_wr = w; iir_rd = r; hold_empty = he; shift_empty = se;
    @(negedge clk);
    thr_wr = 0; iir_rd = 0; hold_empty = 0; shift_empty = 0;
    #1;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    set_quiet();
    thr_wr = 0; iir_rd = 0; hold_empty = 0; shift_empty = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R9 reset state
    ier = 4'b0010; #1;
    chk("R9", "thre", {7'd0, thre}, 8'd1);
    chk("R9", "temt", {7'd0, temt}, 8'd1);
    chk("R9", "iir",  iir, 8'h01);
    chk("R6", "irq idle", {7'd0, irq}, 8'd0);

    // Table walk: priority with the pending flag clear
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ier, oe, bi, dr, fe, cnt, trig, to, delta} = VEC[i][30:8];
      #1;
      chk("R1-R6 vector", $sformatf("iir #%0d", i), iir, VEC[i][7:0]);
      chk("R6", $sformatf("irq #%0d", i), {7'd0, irq}, {7'd0, ~VEC[i][0]});
    end

    // R10 / R4 holding empty raises pending
    set_quiet(); ier = 4'b0010;
    pulse(0, 0, 1, 0);
    chk("R10", "thre set", {7'd0, thre}, 8'd1);
    chk("R4", "thre id", iir, 8'h02);

    // R4 received data outranks transmit empty
    ier = 4'b0011; dr = 1; #1;
    chk("R4", "rx over thre", iir, 8'h04);
    // R7 read reporting rx data leaves pending set
    pulse(0, 1, 0, 0);
    dr = 0; #1;
    chk("R7", "pending kept", iir, 8'h02);
    // R4 modem below transmit empty
    ier = 4'b1010; delta = 4'h1; #1;
    chk("R4", "thre over modem", iir, 8'h02);
    // R7 read while THRE shown clears it
    pulse(0, 1, 0, 0);
    chk("R7", "cleared to modem", iir, 8'h00);
    delta = 0; ier = 4'b0010; #1;
    chk("R7", "idle after read", iir, 8'h01);

    // R8 FIFO-mode write clears THRE and TEMT
    fe = 1;
    pulse(0, 0, 1, 0);
    chk("R10", "pending again", iir, 8'hC2);
    pulse(1, 0, 0, 0);
    chk("R8", "thre cleared", {7'd0, thre}, 8'd0);
    chk("R8", "temt cleared fifo", {7'd0, temt}, 8'd0);
    chk("R8", "pending cleared", iir, 8'hC1);
    pulse(0, 0, 1, 0);
    chk("R10", "temt still low", {7'd0, temt}, 8'd0);
    pulse(0, 0, 0, 1);
    chk("R10", "temt set", {7'd0, temt}, 8'd1);

    // R8 non-FIFO write keeps TEMT
    fe = 0;
    pulse(1, 0, 0, 0);
    chk("R8", "thre cleared nofifo", {7'd0, thre}, 8'd0);
    chk("R8", "temt kept nofifo", {7'd0, temt}, 8'd1);
    // R8 write beats a simultaneous empty event
    pulse(1, 0, 1, 0);
    chk("R8", "write wins thre", {7'd0, thre}, 8'd0);
    chk("R8", "write wins id", iir, 8'h01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule